// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer for 9-bit words. The write port and the read port each run on their own clock. The two clocks may be one shared clock or two unrelated clocks. Each port is qualified by a pair of enable inputs, and an operation happens only when both of its enables are high. The depth is a parameter, a power of two from 256 to 8192.

Four status flags are provided. Full and almost-full are produced in the write clock domain. Empty and almost-empty are produced in the read clock domain. The almost thresholds are held in two offset registers. A load strobe on the write port redirects enabled write cycles into those registers. The first such cycle writes the empty-side offset and the next one writes the full-side offset.

Reading is in standard mode: a granted read loads the next word into an output register on that read edge. An output-enable input gates the visible data. While output-enable is low, the data lines read as zero and the valid qualifier is low.

Top module: `prog_flag_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with all 9 bits intact. This holds both when the two clocks are one clock and when they are unrelated.
- R2: A write is accepted on a rising write-clock edge only when `wr_en_a` and `wr_en_b` are both 1, `ld_ofs` is 0 and `full` is 0.
- R3: A read is granted on a rising read-clock edge only when `rd_en_a` and `rd_en_b` are both 1 and `empty` is 0. A granted read loads `dout` on that same edge.
- R4: Pointers cross between the clock domains in Gray code, so a crossing pointer changes by at most one bit per edge. With a shared clock, `empty` falls on the third read edge after the write edge, and `full` falls on the third write edge after the read edge.
- R5: A write attempted while `full` is 1 is ignored. No word is stored and the write pointer does not move.
- R6: A read attempted while `empty` is 1 is ignored. The read pointer and the output register keep their values.
- R7: After reset, `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `dout_vld`=0, and both offsets are 7.
- R8: `almost_empty` is 1 when the stored count is at or below the empty-side offset. `almost_full` is 1 when the free space (depth minus count) is at or below the full-side offset.
- R9: While `ld_ofs` is 1, each write-clock cycle with both write enables high stores `din` into an offset register instead of the FIFO. The first such cycle writes the empty-side offset and the second writes the full-side offset. Dropping `ld_ofs` returns the sequence to the empty-side offset.
- R10: When `out_en` is 0, `dout` is 0 and `dout_vld` is 0. When `out_en` is 1, `dout` shows the output register and `dout_vld` is 1 once at least one read has been granted since reset.
- R11: `full` rises on the same write edge that stores the word which fills the last free location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| wr_clk | input | 1 | Write clock |
| wr_en_a | input | 1 | Write enable, first of the pair |
| wr_en_b | input | 1 | Write enable, second of the pair |
| ld_ofs | input | 1 | Offset load strobe (redirects enabled writes into the offset registers) |
| din | input | 9 | Write data, also the offset value while loading |
| full | output | 1 | No free location |
| almost_full | output | 1 | Free space at or below the full-side offset |
| rd_clk | input | 1 | Read clock |
| rd_en_a | input | 1 | Read enable, first of the pair |
| rd_en_b | input | 1 | Read enable, second of the pair |
| out_en | input | 1 | Output enable for `dout` |
| dout | output | 9 | Read data, 0 while `out_en` is low |
| dout_vld | output | 1 | Output data valid qualifier |
| empty | output | 1 | No stored word |
| almost_empty | output | 1 | Stored count at or below the empty-side offset |

## Verification
Results fall due at different times after a stimulus:
- A granted read loads `dout` on its own read edge.
- `full` and `almost_full` react on the write edge of the causing write.
- A change made by the other port reaches a flag only three edges later, because it passes through the two-flop synchronizer and then the flag register.

The bench drives its inputs on falling edges and samples on the falling edge just after the edge where each result is due. For the three-edge crossings it checks the falling edges on both sides of the transition. Data words are compared against a scoreboard queue one read edge after each granted read. Flag levels are checked only after enough edges have passed for the crossing to settle.

// File: rtl/pff_pkg.sv
package pff_pkg;
  localparam int DATA_W  = 9;
  localparam int DEF_OFS = 7;

  typedef enum logic {
    OFS_SLOT_EMPTY = 1'b0,
    OFS_SLOT_FULL  = 1'b1
  } ofs_slot_e;
endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pff_ram.sv
module pff_ram #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pff_wr_ctl.sv
module pff_wr_ctl
  import pff_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  input  logic [AW:0]       rgray_s,
  output logic [AW:0]       wbin,
  output logic [AW:0]       wgray,
  output logic              push,
  output logic              full,
  output logic              afull,
  output logic [AW:0]       ofs_e
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0] rbin_s, wbin_nx, cnt_nx, ofs_f;
  ofs_slot_e     slot;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign push    = we & ~ld & ~full;
  assign wbin_nx = wbin + PW'(push);
  assign cnt_nx  = wbin_nx - rbin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
      ofs_e <= PW'(DEF_OFS);
      ofs_f <= PW'(DEF_OFS);
      slot  <= OFS_SLOT_EMPTY;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      full  <= (cnt_nx == DEPTH_P);
      afull <= ((DEPTH_P - cnt_nx) <= ofs_f);
      if (!ld) begin
        slot <= OFS_SLOT_EMPTY;
      end else if (we) begin
        if (slot == OFS_SLOT_EMPTY) begin
          ofs_e <= PW'(din);
          slot  <= OFS_SLOT_FULL;
        end else begin
          ofs_f <= PW'(din);
          slot  <= OFS_SLOT_EMPTY;
        end
      end
    end
  end
endmodule

// File: rtl/pff_rd_ctl.sv
module pff_rd_ctl #(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        re,
  input  logic [AW:0] wgray_s,
  input  logic [AW:0] ofs_e,
  output logic [AW:0] rbin,
  output logic [AW:0] rgray,
  output logic        pop,
  output logic        empty,
  output logic        aempty,
  output logic        loaded
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_s, rbin_nx, cnt_nx;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign pop     = re & ~empty;
  assign rbin_nx = rbin + PW'(pop);
  assign cnt_nx  = wbin_s - rbin_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
      loaded <= 1'b0;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= rbin_nx ^ (rbin_nx >> 1);
      empty  <= (cnt_nx == '0);
      aempty <= (cnt_nx <= ofs_e);
      if (pop) loaded <= 1'b1;
    end
  end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              rst,
  input  logic              wr_clk,
  input  logic              wr_en_a,
  input  logic              wr_en_b,
  input  logic              ld_ofs,
  input  logic [DATA_W-1:0] din,
  output logic              full,
  output logic              almost_full,
  input  logic              rd_clk,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              out_en,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              empty,
  output logic              almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wbin, wgray, rbin, rgray, wgray_s, rgray_s, ofs_e;
  logic              push, pop, loaded;
  logic [DATA_W-1:0] dout_q;

  pff_wr_ctl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(rst), .we(wr_en_a & wr_en_b), .ld(ld_ofs), .din(din),
    .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray), .push(push),
    .full(full), .afull(almost_full), .ofs_e(ofs_e)
  );

  pff_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s));
  pff_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s));

  pff_rd_ctl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rst), .re(rd_en_a & rd_en_b), .wgray_s(wgray_s),
    .ofs_e(ofs_e), .rbin(rbin), .rgray(rgray), .pop(pop),
    .empty(empty), .aempty(almost_empty), .loaded(loaded)
  );

  pff_ram #(.AW(AW), .DW(DATA_W)) u_ram (
    .wclk(wr_clk), .we(push), .waddr(wbin[AW-1:0]), .wdata(din),
    .rclk(rd_clk), .re(pop), .raddr(rbin[AW-1:0]), .rdata(dout_q)
  );

  assign dout     = out_en ? dout_q : '0;
  assign dout_vld = out_en & loaded;
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
  parameter int PW = 9
) (
  input logic          rst,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_en_a,
  input logic          wr_en_b,
  input logic          ld_ofs,
  input logic          full,
  input logic          rd_en_a,
  input logic          rd_en_b,
  input logic          empty,
  input logic          out_en,
  input logic          dout_vld,
  input logic [8:0]    dout,
  input logic [8:0]    dout_q,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] rgray
);
  // R5
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (rst)
    (full && wr_en_a && wr_en_b && !ld_ofs) |=> $stable(wbin));
  // R2
  wr_pair_gate_chk: assert property (@(posedge wr_clk) disable iff (rst)
    !(wr_en_a && wr_en_b) |=> $stable(wbin));
  // R9
  ofs_load_nostore_chk: assert property (@(posedge wr_clk) disable iff (rst)
    ld_ofs |=> $stable(wbin));
  // R6
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (rst)
    (empty && rd_en_a && rd_en_b) |=> ($stable(rbin) && $stable(dout_q)));
  // R3
  rd_pair_gate_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !(rd_en_a && rd_en_b) |=> $stable(rbin));
  // R4
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (rst)
    1'b1 |=> $onehot0(wgray ^ $past(wgray)));
  // R4
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (rst)
    1'b1 |=> $onehot0(rgray ^ $past(rgray)));
  // R10
  oe_gate_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !out_en |-> (!dout_vld && dout == 9'd0));
endmodule

bind prog_flag_fifo pff_checker #(.PW(PW)) u_chk (
  .rst(rst), .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_en_a(wr_en_a),
  .wr_en_b(wr_en_b), .ld_ofs(ld_ofs), .full(full), .rd_en_a(rd_en_a),
  .rd_en_b(rd_en_b), .empty(empty), .out_en(out_en), .dout_vld(dout_vld),
  .dout(dout), .dout_q(dout_q), .wbin(wbin), .wgray(wgray), .rbin(rbin),
  .rgray(rgray)
);

// File: tb/prog_flag_fifo_bench.sv
`timescale 1ns/1ps
module prog_flag_fifo_bench;
  localparam int DEPTH = 256;

  logic clk_a = 1'b0, clk_b = 1'b0, share = 1'b1;
  logic rst = 1'b1;
  logic wr_en_a = 0, wr_en_b = 0, ld_ofs = 0, rd_en_a = 0, rd_en_b = 0, out_en = 1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic full, almost_full, dout_vld, empty, almost_empty, wr_clk, rd_clk;
  logic pend = 1'b0;
  logic done = 1'b0;
  int   checks = 0, fails = 0;
  logic [8:0] sb [$];
  logic [8:0] seed = 9'd17;

  always #2 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;
  assign wr_clk = clk_a;
  assign rd_clk = share ? clk_a : clk_b;

  prog_flag_fifo #(.DEPTH(DEPTH)) u_prog_flag_fifo (
    .rst(rst), .wr_clk(wr_clk), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
    .ld_ofs(ld_ofs), .din(din), .full(full), .almost_full(almost_full),
    .rd_clk(rd_clk), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
    .dout(dout), .dout_vld(dout_vld), .empty(empty), .almost_empty(almost_empty)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: a read granted at a posedge is compared at the next negedge (R1, R3)
  always @(posedge rd_clk) pend <= !rst && rd_en_a && rd_en_b && !empty;
  always @(negedge rd_clk) begin
    if (pend) begin
      if (sb.size() == 0) chk(int'(dout), -1, "R1 read with empty scoreboard");
      else chk(int'(dout), int'(sb.pop_front()), "R1 data order");
    end
  end

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      seed = {seed[7:0], seed[8] ^ seed[4]};
      din = seed; wr_en_a = 1; wr_en_b = 1;
      if (!full) sb.push_back(seed);
    end
    @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0;
  endtask

  task automatic pop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk); rd_en_a = 1; rd_en_b = 1;
    end
    @(negedge rd_clk); rd_en_a = 0; rd_en_b = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic do_reset(input logic sh);
    rst = 1; share = sh;
    repeat (6) @(negedge clk_b);
    @(negedge wr_clk); rst = 0;
    settle(2);
  endtask

  initial begin
    logic [8:0] held;
    int wrote;
    do_reset(1'b1);
    // R7 reset state
    chk(empty, 1, "R7 empty"); chk(almost_empty, 1, "R7 almost_empty");
    chk(full, 0, "R7 full"); chk(almost_full, 0, "R7 almost_full");
    chk(dout_vld, 0, "R7 dout_vld");

    // R2: one enable only stores nothing
    @(negedge wr_clk); wr_en_a = 1; din = 9'h1AA;
    @(negedge wr_clk); wr_en_a = 0; wr_en_b = 1;
    @(negedge wr_clk); wr_en_b = 0;
    settle(5); chk(empty, 1, "R2 single write enable");

    // R4: empty falls on the third read edge after the write edge
    push(1);
    chk(empty, 1, "R4 empty +0"); settle(2);
    chk(empty, 1, "R4 empty +2"); settle(1);
    chk(empty, 0, "R4 empty +3");

    // R3: one read enable grants nothing
    @(negedge rd_clk); rd_en_a = 1;
    @(negedge rd_clk); rd_en_a = 0; rd_en_b = 1;
    @(negedge rd_clk); rd_en_b = 0;
    chk(empty, 0, "R3 single read enable"); chk(dout_vld, 0, "R3 no grant yet");
    pop(1);
    chk(empty, 1, "R3 empty after last read"); chk(dout_vld, 1, "R10 valid after read");
    held = dout;
    @(negedge rd_clk); out_en = 0; #0.1;
    chk(dout, 0, "R10 dout gated"); chk(dout_vld, 0, "R10 valid gated");
    out_en = 1;

    // R6: reads while empty are ignored
    pop(3); settle(1);
    chk(dout, held, "R6 dout held"); chk(empty, 1, "R6 still empty");

    // R8 default offsets of 7
    push(7); settle(4); chk(almost_empty, 1, "R8 count 7 almost_empty");
    push(1); settle(4); chk(almost_empty, 0, "R8 count 8 almost_empty");
    push(240); chk(almost_full, 0, "R8 count 248 almost_full");
    push(1); chk(almost_full, 1, "R8 count 249 almost_full");
    push(6); chk(full, 0, "R11 count 255 full");
    push(1); chk(full, 1, "R11 full on filling edge");
    push(2); chk(sb.size(), DEPTH, "R5 writes while full not queued");
    pop(1);
    settle(2); chk(full, 1, "R4 full +2");
    settle(1); chk(full, 0, "R4 full +3");
    pop(255); settle(5);
    chk(empty, 1, "R5 drained empty"); chk(sb.size(), 0, "R5 no extra word");

    // R9 offset load: empty-side 3, then full-side 10
    @(negedge wr_clk); ld_ofs = 1; wr_en_a = 1; wr_en_b = 1; din = 9'd3;
    @(negedge wr_clk); din = 9'd10;
    @(negedge wr_clk); ld_ofs = 0; wr_en_a = 0; wr_en_b = 0;
    settle(5); chk(empty, 1, "R9 load stores no word");
    push(3); settle(4); chk(almost_empty, 1, "R9 count 3 almost_empty");
    push(1); settle(4); chk(almost_empty, 0, "R9 count 4 almost_empty");
    push(241); chk(almost_full, 0, "R9 count 245 almost_full");
    push(1); chk(almost_full, 1, "R9 count 246 almost_full");
    pop(246); settle(5); chk(sb.size(), 0, "R1 shared clock drain");

    // R1: unrelated clocks, patterned enables
    do_reset(1'b0);
    chk(almost_empty, 1, "R7 offsets back to 7 (empty side)");
    wrote = 0;
    fork
      begin
        for (int i = 0; i < 400; i++) begin
          @(negedge wr_clk);
          seed = {seed[7:0], seed[8] ^ seed[4]};
          din = seed;
          wr_en_a = (i % 4 != 1); wr_en_b = (i % 5 != 2);
          if (wr_en_a && wr_en_b && !full) begin sb.push_back(seed); wrote++; end
        end
        @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0;
      end
      begin
        for (int i = 0; i < 200; i++) begin
          @(negedge rd_clk); rd_en_a = (i % 3 != 0); rd_en_b = 1;
        end
        @(negedge rd_clk); rd_en_a = 0; rd_en_b = 0;
      end
    join
    pop(DEPTH + 20); settle(5);
    chk(sb.size(), 0, "R1 async clocks drain");
    chk(empty, 1, "R1 async empty at end");
    chk(wrote > 100, 1, "R1 async traffic volume");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule